// File: doc/BRIEF.md
# GPIO Interrupt Channel Selector

This block turns a wide bus of GPIO interrupt lines into a bank of 32 interrupt request channels. Each channel picks one line from the source bus through a 7-bit index. It watches that line for a rising edge, a falling edge, a high level or a low level. When the chosen condition occurs and the channel is enabled, the channel latches a status flag and drives an active-high request output.

Software sets up the channels through a simple 32-bit register bus. The select words pack four channels each: a source index and an enable bit per byte. The sense words pack sixteen channels each, with a 2-bit code per channel. One register reads back all status flags. A write-one-to-clear register acknowledges edge events. Level-mode flags are not cleared by software: they follow the source and drop by themselves once the source goes inactive. Each source line passes through two flops before selection.

Top module: `gpint_chansel`

## Requirements
- R1: After reset every select word, every sense word and the status register read 0, and irq_out is 0.
- R2: Channel n is configured in the select word at address 0x30 + 4*(n/4), byte n%4. Bits [6:0] of that byte are the source index and bit 7 is the enable. Its 2-bit sense code sits at bits [2*(n%16)+1 : 2*(n%16)] of the sense word at 0x28 + 4*(n/16). Its flag is bit n of the status register at 0x20 and of irq_out. Both kinds of configuration word read back exactly as written.
- R3: With sense code 0 (rising edge), a 0-to-1 change on the selected source sets the status flag. The flag appears on the third rising clock edge after the source changes and then stays set after the source returns to 0.
- R4: With sense code 1 (falling edge), a 1-to-0 change on the selected source sets the flag. A rising change does not set it.
- R5: With sense code 2 (high level), the flag is 1 while the selected source is 1. It returns to 0 by itself, three edges after the source falls.
- R6: With sense code 3 (low level), the flag is 1 while the selected source is 0 and returns to 0 after the source rises.
- R7: A write to address 0x24 clears, on that write's clock edge, the status flag of each channel whose data bit is 1, but only for channels in an edge mode (codes 0 or 1). In a level mode the write has no effect.
- R8: A disabled channel neither sets its flag nor asserts irq_out. The selected source is still tracked while disabled, so enabling a channel whose source is already high in rising mode raises no flag.
- R9: Indexes 0 to 0x55 select the matching source bit. An index above 0x55 selects an input that never raises the flag, in every sense mode.
- R10: When a new edge event and a clear write for the same channel fall on the same clock edge, the flag ends up set.
- R11: Writes to the status address 0x20 do not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 86 | Asynchronous GPIO interrupt lines |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_out | output | 32 | Active-high request per channel |

## Verification
A new edge event and a software clear for the same channel can land on one clock edge. This is the race a handler meets when it acknowledges a flag just as the next edge arrives. The bench provokes it by counting the two synchronizer stages and the detect stage after a source change, then placing the clear write on the exact edge where the new event reaches the flag. It judges the result by reading the flag back as still set, next to a plain clear that is shown to drop it.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

  typedef enum logic [1:0] {
    SNS_RISE = 2'd0,
    SNS_FALL = 2'd1,
    SNS_HIGH = 2'd2,
    SNS_LOW  = 2'd3
  } sense_e;

  localparam int STAT_ADR = 32'h20;
  localparam int CLR_ADR  = 32'h24;
  localparam int SNS_ADR  = 32'h28;
  localparam int SEL_ADR  = 32'h30;

  localparam int CH_PER_SEL = 4;
  localparam int CH_PER_SNS = 16;

endpackage

// File: rtl/gpint_sync.sv
module gpint_sync #(
  parameter int WIDTH = 86
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] meta_d;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  always_comb begin
    meta_d = d_async;
    hold_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign d_sync = hold_q;

endmodule

// File: rtl/gpint_cfg.sv
module gpint_cfg
  import gpint_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  input  logic [NUM_CH-1:0]            status_i,
  output logic [31:0]                  bus_rdata,
  output logic [NUM_CH-1:0][IDX_W-1:0] ch_idx,
  output logic [NUM_CH-1:0]            ch_en,
  output logic [NUM_CH-1:0][1:0]       ch_sense,
  output logic [NUM_CH-1:0]            clr_vec
);

  localparam int SEL_WORDS = (NUM_CH + CH_PER_SEL - 1) / CH_PER_SEL;
  localparam int SNS_WORDS = (NUM_CH + CH_PER_SNS - 1) / CH_PER_SNS;

  logic [31:0]          sel_q [SEL_WORDS];
  logic [SEL_WORDS-1:0] sel_we;
  logic [31:0]          sns_q [SNS_WORDS];
  logic [SNS_WORDS-1:0] sns_we;

  generate
    for (genvar k = 0; k < SEL_WORDS; k++) begin : g_sel
      assign sel_we[k] = bus_wr && (bus_addr == ADDR_W'(SEL_ADR + 4 * k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sel_q[k] <= '0;
        else if (sel_we[k])  sel_q[k] <= bus_wdata;
      end
    end

    for (genvar k = 0; k < SNS_WORDS; k++) begin : g_sns
      assign sns_we[k] = bus_wr && (bus_addr == ADDR_W'(SNS_ADR + 4 * k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sns_q[k] <= '0;
        else if (sns_we[k])  sns_q[k] <= bus_wdata;
      end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_fld
      assign ch_idx[n]   = sel_q[n / CH_PER_SEL][8 * (n % CH_PER_SEL) +: IDX_W];
      assign ch_en[n]    = sel_q[n / CH_PER_SEL][8 * (n % CH_PER_SEL) + 7];
      assign ch_sense[n] = sns_q[n / CH_PER_SNS][2 * (n % CH_PER_SNS) +: 2];
    end
  endgenerate

  assign clr_vec = (bus_wr && (bus_addr == ADDR_W'(CLR_ADR))) ?
                   bus_wdata[NUM_CH-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(STAT_ADR)) bus_rdata = 32'(status_i);
    for (int k = 0; k < SEL_WORDS; k++) begin
      if (bus_addr == ADDR_W'(SEL_ADR + 4 * k)) bus_rdata = sel_q[k];
    end
    for (int k = 0; k < SNS_WORDS; k++) begin
      if (bus_addr == ADDR_W'(SNS_ADR + 4 * k)) bus_rdata = sns_q[k];
    end
  end

endmodule

// File: rtl/gpint_chan.sv
module gpint_chan
  import gpint_pkg::*;
#(
  parameter int SRC_W = 86,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [IDX_W-1:0] idx,
  input  logic             en,
  input  logic [1:0]       sense,
  input  logic             clr,
  output logic             stat,
  output logic             set_o,
  output logic             bad_o
);

  localparam int PAD_W = 1 << IDX_W;

  logic [PAD_W-1:0] pad;
  logic             in_rng;
  logic             picked;
  logic             prev_q;
  logic             prev_d;
  logic             hit;
  logic             edge_m;
  logic             stat_q;
  logic             stat_d;

  assign pad    = PAD_W'(src);
  assign in_rng = int'(idx) < SRC_W;
  assign picked = in_rng & pad[idx];
  assign edge_m = ~sense[1];

  always_comb begin
    unique case (sense_e'(sense))
      SNS_RISE: hit =  picked & ~prev_q;
      SNS_FALL: hit = ~picked &  prev_q;
      SNS_HIGH: hit =  picked;
      SNS_LOW:  hit = ~picked;
      default:  hit = 1'b0;
    endcase
  end

  assign set_o = en & in_rng & hit;

  always_comb begin
    prev_d = picked;
    if (edge_m) stat_d = set_o | (stat_q & ~clr);
    else        stat_d = set_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      stat_q <= stat_d;
    end
  end

  assign stat  = stat_q;
  assign bad_o = ~in_rng;

endmodule

// File: rtl/gpint_chansel.sv
module gpint_chansel
  import gpint_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int SRC_W  = 86,
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq_out
);

  logic [SRC_W-1:0]            src_s;
  logic [NUM_CH-1:0][IDX_W-1:0] ch_idx;
  logic [NUM_CH-1:0][1:0]       ch_sense;
  logic [NUM_CH-1:0]            en_vec;
  logic [NUM_CH-1:0]            clr_vec;
  logic [NUM_CH-1:0]            stat_vec;
  logic [NUM_CH-1:0]            set_vec;
  logic [NUM_CH-1:0]            bad_vec;
  logic [NUM_CH-1:0]            edge_vec;

  gpint_sync #(.WIDTH(SRC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (src_in),
    .d_sync  (src_s)
  );

  gpint_cfg #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_i  (stat_vec),
    .bus_rdata (bus_rdata),
    .ch_idx    (ch_idx),
    .ch_en     (en_vec),
    .ch_sense  (ch_sense),
    .clr_vec   (clr_vec)
  );

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      gpint_chan #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_s),
        .idx   (ch_idx[n]),
        .en    (en_vec[n]),
        .sense (ch_sense[n]),
        .clr   (clr_vec[n]),
        .stat  (stat_vec[n]),
        .set_o (set_vec[n]),
        .bad_o (bad_vec[n])
      );
      assign edge_vec[n] = ~ch_sense[n][1];
    end
  endgenerate

  assign irq_out = stat_vec & en_vec;

endmodule

// File: rtl/gpint_chansel_chk.sv
module gpint_chansel_chk #(
  parameter int NUM_CH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] stat_vec,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] edge_vec,
  input logic [NUM_CH-1:0] set_vec,
  input logic [NUM_CH-1:0] clr_vec,
  input logic [NUM_CH-1:0] bad_vec
);

  // R10: any event leaves the flag set on the next edge, clear or not
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat_vec & $past(set_vec)) == '0));

  // R7: a clear in edge mode without a competing event drops the flag
  p_edge_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_vec & $past(clr_vec & edge_vec & ~set_vec)) == '0));

  // R5 and R6: a level-mode flag follows the level condition
  p_lvl_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_vec ^ $past(set_vec)) & $past(~edge_vec)) == '0));

  // R8: no flag rises on a disabled channel
  p_dis_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_vec & ~$past(stat_vec) & ~$past(en_vec)) == '0));

  // R9: no flag rises on a channel with an out-of-range index
  p_oor_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_vec & ~$past(stat_vec) & $past(bad_vec)) == '0));

endmodule

bind gpint_chansel gpint_chansel_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stat_vec (stat_vec),
  .en_vec   (en_vec),
  .edge_vec (edge_vec),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .bad_vec  (bad_vec)
);

// File: tb/gpint_chansel_tb.sv
module gpint_chansel_tb;

  localparam int CLK_P  = 10;
  localparam int NUM_CH = 32;
  localparam int SRC_W  = 86;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [SRC_W-1:0]  src_in = '0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_CH-1:0] irq_out;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] sel_sh [8];
  logic [31:0] sns_sh [2];

  always #(CLK_P / 2) clk = ~clk;

  gpint_chansel u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 8'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_ch(input int n, input int idx, input bit en, input int sns);
    sns_sh[n / 16][2 * (n % 16) +: 2] = 2'(sns);
    wr(32'h28 + 4 * (n / 16), sns_sh[n / 16]);
    sel_sh[n / 4][8 * (n % 4) +: 8] = {en, 7'(idx)};
    wr(32'h30 + 4 * (n / 4), sel_sh[n / 4]);
  endtask

  function automatic logic [31:0] bitv(input int n);
    return 32'h1 << n;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(32'h20, d); chk("R1 status", d, 0);
    rd(32'h30, d); chk("R1 select word", d, 0);
    rd(32'h2C, d); chk("R1 sense word", d, 0);
    chk("R1 irq_out", irq_out, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(32'h34, 32'hA583_12C4);
    rd(32'h34, d); chk("R2 select readback", d, 32'hA583_12C4);
    wr(32'h2C, 32'h5A3C_F00F);
    rd(32'h2C, d); chk("R2 sense readback", d, 32'h5A3C_F00F);
    wr(32'h34, 0); wr(32'h2C, 0);
    rd(32'h34, d); chk("R2 select cleared", d, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    cfg_ch(13, 32'h21, 1'b1, 0);
    src_in[32'h21] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 not yet after two edges", irq_out, 0);
    @(negedge clk);
    chk("R3 irq on third edge", irq_out, bitv(13));
    rd(32'h20, d); chk("R3 status bit 13", d, bitv(13));
    src_in[32'h21] = 1'b0; settle();
    rd(32'h20, d); chk("R3 flag latched", d, bitv(13));
    wr(32'h20, 32'h0);
    rd(32'h20, d); chk("R11 status write ignored", d, bitv(13));
    wr(32'h24, bitv(13));
    rd(32'h20, d); chk("R7 edge clear", d, 0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    cfg_ch(22, 32'h55, 1'b1, 1);
    src_in[32'h55] = 1'b1; settle();
    rd(32'h20, d); chk("R4 rising ignored", d, 0);
    src_in[32'h55] = 1'b0; settle();
    rd(32'h20, d); chk("R4 falling sets (index 0x55)", d, bitv(22));
    chk("R4 irq", irq_out, bitv(22));
    wr(32'h24, bitv(22));
    rd(32'h20, d); chk("R7 falling clear", d, 0);
    cfg_ch(22, 0, 1'b0, 0);
  endtask

  task automatic t_high();
    logic [31:0] d;
    cfg_ch(0, 0, 1'b1, 2);
    src_in[0] = 1'b1; settle();
    rd(32'h20, d); chk("R5 high level sets", d, bitv(0));
    wr(32'h24, bitv(0));
    rd(32'h20, d); chk("R7 level clear ignored", d, bitv(0));
    src_in[0] = 1'b0; settle();
    rd(32'h20, d); chk("R5 self clear", d, 0);
    cfg_ch(0, 0, 1'b0, 0);
  endtask

  task automatic t_low();
    logic [31:0] d;
    cfg_ch(31, 32'h40, 1'b1, 3);
    @(negedge clk);
    chk("R6 low level asserts", irq_out, bitv(31));
    src_in[32'h40] = 1'b1; settle();
    rd(32'h20, d); chk("R6 clears on high", d, 0);
    cfg_ch(31, 0, 1'b0, 0);
    src_in[32'h40] = 1'b0;
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    cfg_ch(9, 5, 1'b0, 0);
    src_in[5] = 1'b1; settle();
    rd(32'h20, d); chk("R8 disabled no flag", d, 0);
    chk("R8 disabled no irq", irq_out, 0);
    cfg_ch(9, 5, 1'b1, 0); settle();
    rd(32'h20, d); chk("R8 enable with high source", d, 0);
    src_in[5] = 1'b0; settle();
    src_in[5] = 1'b1; settle();
    rd(32'h20, d); chk("R8 enabled edge sets", d, bitv(9));
    wr(32'h24, bitv(9));
    cfg_ch(9, 0, 1'b0, 0);
    src_in[5] = 1'b0;
  endtask

  task automatic t_oor();
    logic [31:0] d;
    cfg_ch(3, 32'h56, 1'b1, 3); settle();
    rd(32'h20, d); chk("R9 index 0x56 low mode", d, 0);
    cfg_ch(3, 32'h7F, 1'b1, 2); settle();
    rd(32'h20, d); chk("R9 index 0x7F high mode", d, 0);
    chk("R9 irq", irq_out, 0);
    cfg_ch(3, 0, 1'b0, 0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    src_in[32'h21] = 1'b1;
    settle();
    src_in[32'h21] = 1'b0; settle();
    rd(32'h20, d); chk("R10 primed", d, bitv(13));
    src_in[32'h21] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = bitv(13);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(32'h20, d); chk("R10 event beats clear", d, bitv(13));
    chk("R10 irq held", irq_out, bitv(13));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) sel_sh[i] = '0;
    for (int i = 0; i < 2; i++) sns_sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_rise();
    t_fall();
    t_high();
    t_low();
    t_disabled();
    t_oor();
    t_setclr();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule